// File: doc/BRIEF.md
# Integer Execute Stage for a 32-bit RISC Subset

This block computes the write-back result of one integer instruction from its decoded fields and its two register operand values. It is purely combinational. An opcode of zero selects the register-register group, and the function code then picks the operation. Any other supported opcode selects an immediate form, which uses the 16-bit immediate field after zero extension, sign extension or a shift into the upper half.

Branches, jumps, memory access and overflow traps belong to neighbouring blocks. Signed and unsigned adds therefore compute the same wrapped sum. Any opcode or function code outside the supported set drops the write and raises an illegal-instruction flag. The pipeline stage around the block registers its outputs and writes `wb_data` into the register file when `wb_en` is high.

Top module: `exu_top`

## Requirements
- R1: With opcode 0, function codes 32 and 33 write rs+rt and codes 34 and 35 write rs−rt, both modulo 2^32 with no trap.
- R2: With opcode 0, function code 36 writes rs AND rt, 37 writes rs OR rt and 39 writes NOT(rs OR rt).
- R3: With opcode 0, function code 42 writes 1 when rs < rt as two's complement numbers and 0 otherwise. Function code 43 makes the same comparison on unsigned values.
- R4: With opcode 0, function code 0 writes rt shifted left by the 5-bit shift amount and code 2 writes rt shifted right logically by it. The rs value has no effect on either result.
- R5: Opcodes 0x08 and 0x09 write rs plus the sign-extended immediate, where bit 15 fills the upper half, modulo 2^32.
- R6: Opcode 0x0c writes rs AND the zero-extended immediate, and opcode 0x0d writes rs OR the zero-extended immediate.
- R7: Opcode 0x0a writes 1 when rs is less than the sign-extended immediate as a signed value. Opcode 0x0b sign-extends the immediate and then compares unsigned. Both write 0 otherwise.
- R8: Opcode 0x0f writes the immediate in bits 31:16 with bits 15:0 zero, and rs has no effect.
- R9: The destination index is rd for opcode 0 and rt for every other opcode.
- R10: When the destination index is 0, wb_en is low. The result is still presented on wb_data.
- R11: Any other opcode, or any other function code with opcode 0, drives wb_en low, illegal high and wb_data to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Major opcode field |
| funct_i | input | 6 | Function code for opcode 0 |
| shamt_i | input | 5 | Shift amount field |
| imm_i | input | 16 | Immediate field |
| rt_idx_i | input | 5 | rt register index |
| rd_idx_i | input | 5 | rd register index |
| rs_val_i | input | 32 | Value of register rs |
| rt_val_i | input | 32 | Value of register rt |
| wb_data_o | output | 32 | Result to write back |
| wb_idx_o | output | 5 | Destination register index |
| wb_en_o | output | 1 | Register write enable |
| illegal_o | output | 1 | Unsupported instruction flag |

## Verification
The hardest cases are the extremes of the comparisons and extensions: operand pairs that straddle the sign boundary, and unsigned-immediate compares with a negative immediate. Uniformly random 32-bit operands almost never reach these cases. The stimulus therefore draws operands from a pool that mixes 0, 1, all-ones, the most-negative value and the most-positive value with random words. It also draws immediates with bit 15 set half of the time. Directed vectors then cover each boundary pair and the writes to index 0.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0a;
  localparam logic [5:0] OPC_SLTIU = 6'h0b;
  localparam logic [5:0] OPC_ANDI  = 6'h0c;
  localparam logic [5:0] OPC_ORI   = 6'h0d;
  localparam logic [5:0] OPC_LUI   = 6'h0f;

  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_ADDU = 6'd33;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_SUBU = 6'd35;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_NOR  = 6'd39;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam logic [5:0] FN_SLTU = 6'd43;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SIGN, IMM_ZERO, IMM_UPPER
  } imm_mode_e;

  typedef struct packed {
    alu_op_e   op;
    imm_mode_e imm_mode;
    logic      use_imm;
    logic      dest_rd;
    logic      legal;
  } dec_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o.op       = ALU_ADD;
    dec_o.imm_mode = IMM_SIGN;
    dec_o.use_imm  = 1'b1;
    dec_o.dest_rd  = 1'b0;
    dec_o.legal    = 1'b1;
    unique case (opcode_i)
      OPC_RTYPE: begin
        dec_o.use_imm = 1'b0;
        dec_o.dest_rd = 1'b1;
        unique case (funct_i)
          FN_ADD, FN_ADDU: dec_o.op = ALU_ADD;
          FN_SUB, FN_SUBU: dec_o.op = ALU_SUB;
          FN_AND:          dec_o.op = ALU_AND;
          FN_OR:           dec_o.op = ALU_OR;
          FN_NOR:          dec_o.op = ALU_NOR;
          FN_SLT:          dec_o.op = ALU_SLT;
          FN_SLTU:         dec_o.op = ALU_SLTU;
          FN_SLL:          dec_o.op = ALU_SLL;
          FN_SRL:          dec_o.op = ALU_SRL;
          default:         dec_o.legal = 1'b0;
        endcase
      end
      OPC_ADDI, OPC_ADDIU: dec_o.op = ALU_ADD;
      OPC_SLTI:            dec_o.op = ALU_SLT;
      OPC_SLTIU:           dec_o.op = ALU_SLTU;
      OPC_ANDI: begin
        dec_o.op       = ALU_AND;
        dec_o.imm_mode = IMM_ZERO;
      end
      OPC_ORI: begin
        dec_o.op       = ALU_OR;
        dec_o.imm_mode = IMM_ZERO;
      end
      OPC_LUI: begin
        dec_o.op       = ALU_PASSB;
        dec_o.imm_mode = IMM_UPPER;
      end
      default: dec_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/exu_imm_ext.sv
module exu_imm_ext
  import exu_pkg::*;
#(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32,
  localparam int PAD_W = DATA_W - IMM_W
)(
  input  logic [IMM_W-1:0]  imm_i,
  input  imm_mode_e         mode_i,
  output logic [DATA_W-1:0] ext_o
);
  always_comb begin
    unique case (mode_i)
      IMM_ZERO:  ext_o = {{PAD_W{1'b0}}, imm_i};
      IMM_UPPER: ext_o = {imm_i, {PAD_W{1'b0}}};
      default:   ext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    endcase
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
)(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [DATA_W-1:0] res_o
);
  logic lt_s, lt_u;

  always_comb begin
    lt_s = $signed(a_i) < $signed(b_i);
    lt_u = a_i < b_i;
    unique case (op_i)
      ALU_ADD:   res_o = a_i + b_i;
      ALU_SUB:   res_o = a_i - b_i;
      ALU_AND:   res_o = a_i & b_i;
      ALU_OR:    res_o = a_i | b_i;
      ALU_NOR:   res_o = ~(a_i | b_i);
      ALU_SLT:   res_o = {{(DATA_W-1){1'b0}}, lt_s};
      ALU_SLTU:  res_o = {{(DATA_W-1){1'b0}}, lt_u};
      ALU_SLL:   res_o = b_i << shamt_i;
      ALU_SRL:   res_o = b_i >> shamt_i;
      default:   res_o = b_i;
    endcase
  end

  always_comb begin
    if (op_i == ALU_SLT || op_i == ALU_SLTU)
      AST_SLT_IS_BIT: assert (res_o[DATA_W-1:1] == '0); // R3
  end
endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 16,
  parameter int REG_IDXW = 5,
  localparam int SH_W    = $clog2(DATA_W)
)(
  input  logic [5:0]          opcode_i,
  input  logic [5:0]          funct_i,
  input  logic [SH_W-1:0]     shamt_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [REG_IDXW-1:0] rt_idx_i,
  input  logic [REG_IDXW-1:0] rd_idx_i,
  input  logic [DATA_W-1:0]   rs_val_i,
  input  logic [DATA_W-1:0]   rt_val_i,
  output logic [DATA_W-1:0]   wb_data_o,
  output logic [REG_IDXW-1:0] wb_idx_o,
  output logic                wb_en_o,
  output logic                illegal_o
);
  dec_t              dec;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_res;

  exu_decode u_dec (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .dec_o    (dec)
  );

  exu_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
    .imm_i  (imm_i),
    .mode_i (dec.imm_mode),
    .ext_o  (imm_ext)
  );

  always_comb opnd_b = dec.use_imm ? imm_ext : rt_val_i;

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (dec.op),
    .a_i     (rs_val_i),
    .b_i     (opnd_b),
    .shamt_i (shamt_i),
    .res_o   (alu_res)
  );

  always_comb begin
    wb_idx_o  = dec.dest_rd ? rd_idx_i : rt_idx_i;
    illegal_o = ~dec.legal;
    wb_data_o = dec.legal ? alu_res : '0;
    wb_en_o   = dec.legal && (wb_idx_o != '0);
  end

  always_comb begin
    if (wb_idx_o == '0)
      AST_ZERO_REG_QUIET: assert (!wb_en_o); // R10
    if (illegal_o)
      AST_ILLEGAL_NO_WRITE: assert (!wb_en_o && wb_data_o == '0); // R11
    if (opcode_i == OPC_RTYPE)
      AST_RTYPE_DEST: assert (wb_idx_o == rd_idx_i); // R9
    else
      AST_ITYPE_DEST: assert (wb_idx_o == rt_idx_i); // R9
    if (opcode_i == OPC_LUI)
      AST_LUI_LOW_CLEAR: assert (wb_data_o[IMM_W-1:0] == '0); // R8
    if (opcode_i == OPC_ANDI)
      AST_ANDI_HIGH_CLEAR: assert (wb_data_o[DATA_W-1:IMM_W] == '0); // R6
  end
endmodule

// File: tb/exu_top_tb_top.sv
module exu_top_tb_top;
  logic clk;
  logic rst_n;
  logic [5:0]  opcode, funct;
  logic [4:0]  shamt, rt_idx, rd_idx;
  logic [15:0] imm;
  logic [31:0] rs_val, rt_val;
  logic [31:0] wb_data;
  logic [4:0]  wb_idx;
  logic        wb_en, illegal;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  exu_top dut_i (
    .opcode_i (opcode), .funct_i (funct), .shamt_i (shamt), .imm_i (imm),
    .rt_idx_i (rt_idx), .rd_idx_i (rd_idx), .rs_val_i (rs_val), .rt_val_i (rt_val),
    .wb_data_o (wb_data), .wb_idx_o (wb_idx), .wb_en_o (wb_en), .illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // reference model: returns {illegal, data}
  function automatic logic [32:0] model(input logic [5:0] op, input logic [5:0] fn,
      input logic [4:0] sh, input logic [15:0] im, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic bad;
    bad = 1'b0;
    r = 32'h0;
    if (op == 6'd0) begin
      case (fn)
        6'd32, 6'd33: r = a + b;
        6'd34, 6'd35: r = a - b;
        6'd36: r = a & b;
        6'd37: r = a | b;
        6'd39: r = ~(a | b);
        6'd42: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'd43: r = (a < b) ? 32'd1 : 32'd0;
        6'd0:  r = b << sh;
        6'd2:  r = b >> sh;
        default: bad = 1'b1;
      endcase
    end else begin
      case (op)
        6'h08, 6'h09: r = a + sx(im);
        6'h0c: r = a & {16'h0, im};
        6'h0d: r = a | {16'h0, im};
        6'h0a: r = ($signed(a) < $signed(sx(im))) ? 32'd1 : 32'd0;
        6'h0b: r = (a < sx(im)) ? 32'd1 : 32'd0;
        6'h0f: r = {im, 16'h0};
        default: bad = 1'b1;
      endcase
    end
    if (bad) r = 32'h0;
    return {bad, r};
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn, input bit bad);
    if (bad) return "R11";
    if (op == 6'd0) begin
      case (fn)
        6'd32, 6'd33, 6'd34, 6'd35: return "R1";
        6'd36, 6'd37, 6'd39: return "R2";
        6'd42, 6'd43: return "R3";
        default: return "R4";
      endcase
    end
    case (op)
      6'h08, 6'h09: return "R5";
      6'h0c, 6'h0d: return "R6";
      6'h0a, 6'h0b: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sh,
      input logic [15:0] im, input logic [4:0] rti, input logic [4:0] rdi,
      input logic [31:0] a, input logic [31:0] b, input string note);
    logic [32:0] exp;
    logic [4:0]  exp_idx;
    logic        exp_en;
    string       t;
    @(negedge clk);
    opcode = op; funct = fn; shamt = sh; imm = im;
    rt_idx = rti; rd_idx = rdi; rs_val = a; rt_val = b;
    #2;
    exp     = model(op, fn, sh, im, a, b);
    exp_idx = (op == 6'd0) ? rdi : rti;               // R9
    exp_en  = !exp[32] && (exp_idx != 5'd0);          // R10
    t = tag_of(op, fn, exp[32]);
    n_checks++;
    if (wb_data !== exp[31:0] || wb_idx !== exp_idx || wb_en !== exp_en || illegal !== exp[32]) begin
      n_fail++;
      $display("FAIL %s/R9/R10 %s op=%h fn=%0d: got data=%h idx=%0d en=%b ill=%b exp data=%h idx=%0d en=%b ill=%b",
               t, note, op, fn, wb_data, wb_idx, wb_en, illegal, exp[31:0], exp_idx, exp_en, exp[32]);
    end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hffff_ffff;
      3: return 32'h8000_0000;
      4: return 32'h7fff_ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [5:0] itab [7];
    logic [5:0] ftab [11];
    void'($urandom(32'h5eed_1234));
    itab = '{6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d, 6'h0f};
    ftab = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd39, 6'd42, 6'd43, 6'd0, 6'd2};
    rst_n = 1'b0;
    opcode = '0; funct = '0; shamt = '0; imm = '0;
    rt_idx = '0; rd_idx = '0; rs_val = '0; rt_val = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // all-zero fields: shift of 0 to index 0, no write (R4, R10)
    apply(6'd0, 6'd0, 5'd0, 16'h0, 5'd0, 5'd0, 32'h0, 32'h0, "reset-state");
    // R1 wrap without trap
    apply(6'd0, 6'd32, 5'd0, 16'h0, 5'd2, 5'd3, 32'h7fff_ffff, 32'h1, "R1 add wrap");
    apply(6'd0, 6'd35, 5'd0, 16'h0, 5'd2, 5'd3, 32'h0, 32'h1, "R1 subu wrap");
    // R2
    apply(6'd0, 6'd39, 5'd0, 16'h0, 5'd2, 5'd4, 32'h0, 32'h0, "R2 nor zero");
    // R3 sign boundary
    apply(6'd0, 6'd42, 5'd0, 16'h0, 5'd2, 5'd5, 32'h8000_0000, 32'h7fff_ffff, "R3 slt neg");
    apply(6'd0, 6'd43, 5'd0, 16'h0, 5'd2, 5'd5, 32'h8000_0000, 32'h7fff_ffff, "R3 sltu");
    // R4 shifts ignore rs, max shamt
    apply(6'd0, 6'd0, 5'd31, 16'h0, 5'd2, 5'd6, 32'hdead_beef, 32'h3, "R4 sll 31");
    apply(6'd0, 6'd2, 5'd31, 16'h0, 5'd2, 5'd6, 32'h1234_5678, 32'h8000_0000, "R4 srl 31");
    // R5 negative immediate
    apply(6'h08, 6'd0, 5'd0, 16'hffff, 5'd7, 5'd0, 32'h0, 32'h0, "R5 addi -1");
    apply(6'h09, 6'd0, 5'd0, 16'h8000, 5'd7, 5'd0, 32'h0000_8000, 32'h0, "R5 addiu");
    // R6 zero extension
    apply(6'h0c, 6'd0, 5'd0, 16'hffff, 5'd8, 5'd0, 32'hffff_ffff, 32'h0, "R6 andi");
    apply(6'h0d, 6'd0, 5'd0, 16'h8000, 5'd8, 5'd0, 32'h0, 32'h0, "R6 ori");
    // R7 immediate compares
    apply(6'h0a, 6'd0, 5'd0, 16'hffff, 5'd9, 5'd0, 32'hffff_fffe, 32'h0, "R7 slti");
    apply(6'h0b, 6'd0, 5'd0, 16'hffff, 5'd9, 5'd0, 32'h7fff_ffff, 32'h0, "R7 sltiu neg imm");
    // R8
    apply(6'h0f, 6'd0, 5'd0, 16'habcd, 5'd10, 5'd0, 32'hffff_ffff, 32'h0, "R8 lui");
    // R10 write to index 0
    apply(6'h08, 6'd0, 5'd0, 16'h0005, 5'd0, 5'd9, 32'h1, 32'h0, "R10 rt zero");
    // R11 unsupported
    apply(6'h04, 6'd0, 5'd0, 16'h0001, 5'd3, 5'd0, 32'h5, 32'h5, "R11 branch op");
    apply(6'd0, 6'd8, 5'd0, 16'h0, 5'd3, 5'd4, 32'h5, 32'h5, "R11 bad funct");
    apply(6'h23, 6'd0, 5'd0, 16'h0, 5'd3, 5'd4, 32'h5, 32'h5, "R11 load op");

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op, fn;
      int sel;
      sel = int'($urandom % 16);
      if (sel < 7) op = 6'd0;
      else if (sel < 14) op = itab[$urandom % 7];
      else op = 6'($urandom);
      fn = ($urandom % 8 == 0) ? 6'($urandom) : ftab[$urandom % 11];
      apply(op, fn, 5'($urandom),
            ($urandom % 2 == 1) ? (16'h8000 | 16'($urandom)) : 16'($urandom & 32'h7fff),
            5'($urandom), 5'($urandom), pick_val(), pick_val(), "random");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule